// File: doc/BRIEF.md
# Multi-Endpoint Slave FIFO Port

This block is a buffer port that sits on the peripheral side of a shared data bus. An external master reaches it through that bus. Inside are four independent FIFOs. A 2-bit address picks one of them, and the chosen FIFO is both the target of bus reads and writes and the source of the flag outputs. The master uses three strobes: write, read and output-enable. Each strobe is active-low by default, and a 3-bit polarity input can invert any of them.

A mode input selects one of two timing schemes. In synchronous mode, data moves on every rising interface-clock edge while a strobe is asserted. The head word of the selected FIFO is prefetched, so it is on the bus as soon as output-enable is asserted. In asynchronous mode, a word is stored or consumed once, when its strobe is released. The bus is driven only while output-enable and read are both asserted. The strobes are sampled by the interface clock, so each asserted or released level must last at least one clock.

A packet-end input reports how much data the selected FIFO holds. It does this as a one-cycle valid pulse plus a byte count, and it leaves the stored data untouched. Each FIFO is 64 entries deep and has its own level threshold, which is loaded at reset. A per-FIFO word-wide setting chooses between 16-bit and 8-bit storage.

Top module: `epq_port`

## Requirements
- R1: After reset, every FIFO is empty: `flagEmpty`=1 and `flagFull`=0 for all four addresses, `dataDrive`=0 and `pktValid`=0.
- R2: With `asyncMode`=0, each rising clock edge that sees the write strobe asserted stores `dataIn` into the FIFO selected by `fifoAddr`. Holding the strobe for N edges stores N words, and they are read back in the order written.
- R3: With `asyncMode`=1, a word is stored only at the first clock edge that sees the write strobe released after it was asserted. Holding the strobe for many cycles stores exactly one word, which is the `dataIn` present at that edge.
- R4: With `asyncMode`=1, the read pointer advances exactly once for each release of the read strobe, however long the strobe was held.
- R5: With `asyncMode`=0, `dataDrive` follows the output-enable strobe alone, and `dataOut` then shows the oldest stored word without any read strobe. Each rising edge with the read strobe asserted removes one word.
- R6: With `asyncMode`=1, `dataDrive` is 1 only while output-enable and read are both asserted. When `dataDrive` is 0, `dataOut` is 0 (bus released).
- R7: `invPol` bit 0 inverts read, bit 1 inverts write and bit 2 inverts output-enable. A bit of 0 means the strobe is asserted at pin level 0; a bit of 1 means it is asserted at pin level 1.
- R8: `fifoAddr` (0 to 3) selects which FIFO the data and the flags refer to. Writing to one FIFO does not change another FIFO's contents or flags.
- R9: For the selected FIFO, `flagFull`=1 at 64 entries, `flagEmpty`=1 at 0 entries, and `flagLevel`=1 when the entry count is at least that FIFO's threshold. The default thresholds are 4, 5, 2 and 3 for FIFOs 0 to 3.
- R10: FIFOs whose `WORD_WIDE` bit is 0 (FIFOs 1 and 3 by default) keep only `dataIn[7:0]` and read back with bits 15:8 as 0. Wide FIFOs (0 and 2) keep all 16 bits.
- R11: A write to a full FIFO and a read from an empty FIFO are ignored, and neither moves a pointer.
- R12: A rising edge on the active-high `pktEnd` input produces `pktValid`=1 for exactly one cycle, at the edge after `pktEnd` rose. `pktBytes` then equals the selected FIFO's entry count, times 2 if that FIFO is wide. The stored data stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous reset, active low |
| asyncMode | input | 1 | 0: clocked strobes, 1: release-edge strobes |
| invPol | input | 3 | Strobe polarity inversion {oe, wr, rd} |
| fifoAddr | input | 2 | Selected FIFO |
| slRd | input | 1 | Read strobe pin |
| slWr | input | 1 | Write strobe pin |
| slOe | input | 1 | Output-enable strobe pin |
| pktEnd | input | 1 | Packet commit request, active high |
| dataIn | input | 16 | Write data from the master |
| dataOut | output | 16 | Read data toward the master, 0 when not driving |
| dataDrive | output | 1 | Bus driver enable |
| flagFull | output | 1 | Selected FIFO full |
| flagEmpty | output | 1 | Selected FIFO empty |
| flagLevel | output | 1 | Selected FIFO at or above threshold |
| pktValid | output | 1 | One-cycle commit pulse |
| pktBytes | output | 8 | Byte count reported with the commit |

## Verification
The properties assume that `fifoAddr`, `asyncMode` and `invPol` change only while all strobes are idle, and that every strobe level is held across at least one rising clock edge. Under those assumptions, a release seen by the clock corresponds to exactly one transfer. The stimulus changes every input only on the falling clock edge, holds the address throughout each transfer, and changes polarity only together with the pin levels so that no strobe appears to toggle. The flag relations checked over one cycle are stated only for cycles that keep the same address. This leaves a master free to switch FIFOs between transfers without tripping them.

// File: rtl/epq_pkg.sv
package epq_pkg;
  localparam int ADDR_W   = 2;
  localparam int NUM_FIFO = 1 << ADDR_W;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              commit;
    logic              drive;
    logic [ADDR_W-1:0] sel;
  } epqCmd_t;
endpackage

// File: rtl/epq_fifo.sv
module epq_fifo #(
  parameter int   DEPTH  = 64,
  parameter int   DATA_W = 16,
  parameter logic WIDE   = 1'b1,
  parameter int   LEVEL  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         full,
  output logic                         empty,
  output logic                         level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [DATA_W-1:0] MASK =
    WIDE ? {DATA_W{1'b1}} : {{(DATA_W-8){1'b0}}, 8'hFF};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt, lvlReg;
  logic              doPush, doPop;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign level  = (cnt >= lvlReg);
  assign count  = cnt;
  assign rdData = mem[rdPtr];
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData & MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      cnt    <= '0;
      lvlReg <= CNT_W'(LEVEL);
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      unique case ({doPush, doPop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/epq_ctrl.sv
module epq_ctrl
  import epq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              asyncMode,
  input  logic [2:0]        invPol,
  input  logic [ADDR_W-1:0] fifoAddr,
  input  logic              slRd,
  input  logic              slWr,
  input  logic              slOe,
  input  logic              pktEnd,
  output epqCmd_t           cmd
);
  logic rdAct, wrAct, oeAct;
  logic rdPrev, wrPrev, pktPrev;

  // asserted when the pin equals its polarity bit
  assign rdAct = ~(slRd ^ invPol[0]);
  assign wrAct = ~(slWr ^ invPol[1]);
  assign oeAct = ~(slOe ^ invPol[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      pktPrev <= 1'b0;
    end else begin
      rdPrev  <= rdAct;
      wrPrev  <= wrAct;
      pktPrev <= pktEnd;
    end
  end

  always_comb begin
    cmd.sel    = fifoAddr;
    cmd.commit = pktEnd & ~pktPrev;
    if (asyncMode) begin
      cmd.wrEn  = wrPrev & ~wrAct;
      cmd.rdEn  = rdPrev & ~rdAct;
      cmd.drive = oeAct & rdAct;
    end else begin
      cmd.wrEn  = wrAct;
      cmd.rdEn  = rdAct;
      cmd.drive = oeAct;
    end
  end
endmodule

// File: rtl/epq_datapath.sv
module epq_datapath
  import epq_pkg::*;
#(
  parameter int                  DEPTH     = 64,
  parameter int                  DATA_W    = 16,
  parameter logic [NUM_FIFO-1:0] WORD_WIDE = 4'b0101,
  parameter int                  LEVELS [NUM_FIFO] = '{4, 5, 2, 3}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  epqCmd_t                   cmd,
  input  logic [DATA_W-1:0]         dataIn,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      dataDrive,
  output logic                      flagFull,
  output logic                      flagEmpty,
  output logic                      flagLevel,
  output logic                      pktValid,
  output logic [$clog2(DEPTH)+1:0]  pktBytes
);
  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int BYTE_W = CNT_W + 1;

  logic [DATA_W-1:0]   headW [NUM_FIFO];
  logic [CNT_W-1:0]    cntW  [NUM_FIFO];
  logic [NUM_FIFO-1:0] fullV, emptyV, levelV;
  logic [BYTE_W-1:0]   bytesSel;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    epq_fifo #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W),
      .WIDE  (WORD_WIDE[i]),
      .LEVEL (LEVELS[i])
    ) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (cmd.wrEn && cmd.sel == ADDR_W'(i)),
      .pop   (cmd.rdEn && cmd.sel == ADDR_W'(i)),
      .wrData(dataIn),
      .rdData(headW[i]),
      .count (cntW[i]),
      .full  (fullV[i]),
      .empty (emptyV[i]),
      .level (levelV[i])
    );
  end

  assign dataDrive = cmd.drive;
  assign dataOut   = cmd.drive ? headW[cmd.sel] : '0;
  assign flagFull  = fullV[cmd.sel];
  assign flagEmpty = emptyV[cmd.sel];
  assign flagLevel = levelV[cmd.sel];
  assign bytesSel  = WORD_WIDE[cmd.sel] ? {cntW[cmd.sel], 1'b0}
                                        : {1'b0, cntW[cmd.sel]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      pktBytes <= '0;
    end else begin
      pktValid <= cmd.commit;
      if (cmd.commit) pktBytes <= bytesSel;
    end
  end
endmodule

// File: rtl/epq_port.sv
module epq_port
  import epq_pkg::*;
#(
  parameter int                  DEPTH     = 64,
  parameter int                  DATA_W    = 16,
  parameter logic [NUM_FIFO-1:0] WORD_WIDE = 4'b0101,
  parameter int                  LEVELS [NUM_FIFO] = '{4, 5, 2, 3}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     asyncMode,
  input  logic [2:0]               invPol,
  input  logic [ADDR_W-1:0]        fifoAddr,
  input  logic                     slRd,
  input  logic                     slWr,
  input  logic                     slOe,
  input  logic                     pktEnd,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataDrive,
  output logic                     flagFull,
  output logic                     flagEmpty,
  output logic                     flagLevel,
  output logic                     pktValid,
  output logic [$clog2(DEPTH)+1:0] pktBytes
);
  epqCmd_t cmd;

  epq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .asyncMode(asyncMode),
    .invPol   (invPol),
    .fifoAddr (fifoAddr),
    .slRd     (slRd),
    .slWr     (slWr),
    .slOe     (slOe),
    .pktEnd   (pktEnd),
    .cmd      (cmd)
  );

  epq_datapath #(
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .WORD_WIDE(WORD_WIDE),
    .LEVELS   (LEVELS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataDrive(dataDrive),
    .flagFull (flagFull),
    .flagEmpty(flagEmpty),
    .flagLevel(flagLevel),
    .pktValid (pktValid),
    .pktBytes (pktBytes)
  );
endmodule

// File: rtl/epq_checker.sv
module epq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       asyncMode,
  input logic [2:0] invPol,
  input logic [1:0] fifoAddr,
  input logic       slRd,
  input logic       slWr,
  input logic       slOe,
  input logic       dataDrive,
  input logic       flagFull,
  input logic       flagEmpty,
  input logic       pktValid
);
  logic rdOn, wrOn, oeOn;
  assign rdOn = (slRd == invPol[0]);
  assign wrOn = (slWr == invPol[1]);
  assign oeOn = (slOe == invPol[2]);

  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(flagEmpty && flagFull)); // R9

  AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid); // R12

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> oeOn); // R5

  AST_ASYNC_DRIVE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rstN)
    (asyncMode && dataDrive) |-> rdOn); // R6

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (!asyncMode && flagEmpty && wrOn) |=>
      (fifoAddr != $past(fifoAddr) || !flagEmpty)); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!asyncMode && flagFull && wrOn && !rdOn) |=>
      (fifoAddr != $past(fifoAddr) || flagFull)); // R11
endmodule

bind epq_port epq_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .asyncMode(asyncMode),
  .invPol   (invPol),
  .fifoAddr (fifoAddr),
  .slRd     (slRd),
  .slWr     (slWr),
  .slOe     (slOe),
  .dataDrive(dataDrive),
  .flagFull (flagFull),
  .flagEmpty(flagEmpty),
  .pktValid (pktValid)
);

// File: tb/epq_port_bench.sv
module epq_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asyncMode = 1'b0;
  logic [2:0]  invPol = 3'b000;
  logic [1:0]  fifoAddr = 2'd0;
  logic        slRd = 1'b1, slWr = 1'b1, slOe = 1'b1, pktEnd = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataDrive, flagFull, flagEmpty, flagLevel, pktValid;
  logic [7:0]  pktBytes;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  // {addr, write data, expected read data}
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 16'hA5C3, 16'hA5C3},
    {2'd1, 16'h12F0, 16'h00F0},
    {2'd2, 16'hBEEF, 16'hBEEF},
    {2'd3, 16'hFFFF, 16'h00FF},
    {2'd1, 16'h0081, 16'h0081},
    {2'd0, 16'h0000, 16'h0000}
  };

  always #4 clk = ~clk;

  epq_port u_epq_port (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .invPol(invPol),
    .fifoAddr(fifoAddr), .slRd(slRd), .slWr(slWr), .slOe(slOe),
    .pktEnd(pktEnd), .dataIn(dataIn), .dataOut(dataOut),
    .dataDrive(dataDrive), .flagFull(flagFull), .flagEmpty(flagEmpty),
    .flagLevel(flagLevel), .pktValid(pktValid), .pktBytes(pktBytes)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    fifoAddr = a; dataIn = d; slWr = invPol[1];
    @(negedge clk);
    slWr = ~invPol[1];
    @(negedge clk);
  endtask

  task automatic readWord(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    fifoAddr = a; slOe = invPol[2]; slRd = invPol[0];
    #1 v = dataOut;
    @(negedge clk);
    slRd = ~invPol[0]; slOe = ~invPol[2];
    @(negedge clk);
  endtask

  task automatic commit(input logic [1:0] a, output logic [7:0] b,
                        output logic vld);
    @(negedge clk);
    fifoAddr = a; pktEnd = 1'b1;
    @(negedge clk);
    #1 vld = pktValid; b = pktBytes;
    pktEnd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic        vl;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state on every address
    for (int a = 0; a < 4; a++) begin
      fifoAddr = 2'(a);
      #1;
      chk("R1 empty after reset", flagEmpty, 1);
      chk("R1 not full after reset", flagFull, 0);
    end
    chk("R1 no drive after reset", dataDrive, 0);
    chk("R1 no commit after reset", pktValid, 0);

    // R2 R8 R10: table of write/read-back vectors
    for (int i = 0; i < 6; i++) begin
      writeWord(VEC[i][33:32], VEC[i][31:16]);
      readWord(VEC[i][33:32], v);
      chk("R10 R8 table read-back", v, VEC[i][15:0]);
    end

    // R2: held write strobe stores one word per edge, in order
    @(negedge clk);
    fifoAddr = 2'd0; slWr = 1'b0; dataIn = 16'h1111;
    @(negedge clk); dataIn = 16'h2222;
    @(negedge clk); dataIn = 16'h3333;
    @(negedge clk); slWr = 1'b1;
    // R5: prefetch visible with output-enable only
    slOe = 1'b0;
    #1;
    chk("R5 drive follows oe", dataDrive, 1);
    chk("R5 prefetched head", dataOut, 16'h1111);
    slRd = 1'b0;
    @(negedge clk); #1 chk("R5 R2 one pop per edge", dataOut, 16'h2222);
    @(negedge clk); #1 chk("R5 R2 second pop", dataOut, 16'h3333);
    slRd = 1'b1; slOe = 1'b1;
    #1 chk("R6 released bus reads zero", dataOut, 16'h0000);
    readWord(2'd0, v);
    @(negedge clk); fifoAddr = 2'd0; #1;
    chk("R5 fifo drained", flagEmpty, 1);

    // R9 R8: level flag on FIFO 2 (threshold 2)
    writeWord(2'd2, 16'h0A0A);
    #1 chk("R9 below level", flagLevel, 0);
    chk("R8 fifo2 not empty", flagEmpty, 0);
    fifoAddr = 2'd0; #1 chk("R8 fifo0 untouched", flagEmpty, 1);
    writeWord(2'd2, 16'h0B0B);
    #1 chk("R9 level reached", flagLevel, 1);
    readWord(2'd2, v);
    readWord(2'd2, v);
    chk("R9 fifo2 order", v, 16'h0B0B);

    // R9 R11: fill FIFO 3 to 64, write beyond, drain
    @(negedge clk);
    fifoAddr = 2'd3; slWr = 1'b0;
    for (int i = 0; i < 64; i++) begin
      dataIn = 16'(i);
      @(negedge clk);
    end
    slWr = 1'b1;
    #1 chk("R9 full at 64", flagFull, 1);
    chk("R9 not empty when full", flagEmpty, 0);
    writeWord(2'd3, 16'h00AA);
    commit(2'd3, b, vl);
    chk("R12 commit valid", vl, 1);
    chk("R11 R12 full count unchanged", b, 8'd64);
    readWord(2'd3, v);
    chk("R11 first word", v, 16'h0000);
    @(negedge clk); slRd = 1'b0;
    repeat (62) @(negedge clk);
    slRd = 1'b1;
    readWord(2'd3, v);
    chk("R11 last word not overwritten", v, 16'h003F);
    #1 chk("R9 empty after drain", flagEmpty, 1);
    readWord(2'd3, v);
    writeWord(2'd3, 16'h0055);
    readWord(2'd3, v);
    chk("R11 empty read ignored", v, 16'h0055);

    // R12: pulse lasts one cycle while pktEnd stays high
    @(negedge clk); fifoAddr = 2'd3; pktEnd = 1'b1;
    @(negedge clk); #1 chk("R12 pulse high", pktValid, 1);
    @(negedge clk); #1 chk("R12 pulse one cycle", pktValid, 0);
    pktEnd = 1'b0;

    // R3: asynchronous write, strobe held several cycles
    @(negedge clk); asyncMode = 1'b1;
    @(negedge clk);
    fifoAddr = 2'd1; dataIn = 16'h0042; slWr = 1'b0;
    commit(2'd1, b, vl);
    chk("R3 nothing stored while held", b, 8'd0);
    repeat (3) @(negedge clk);
    slWr = 1'b1;
    @(negedge clk); dataIn = 16'h0099;
    commit(2'd1, b, vl);
    chk("R3 one word per release", b, 8'd1);

    // R6: async drive needs oe and rd
    @(negedge clk); slOe = 1'b0;
    #1 chk("R6 oe alone no drive", dataDrive, 0);
    @(negedge clk); slRd = 1'b0;
    #1 chk("R6 oe and rd drive", dataDrive, 1);
    chk("R3 stored release-edge data", dataOut, 16'h0042);
    @(negedge clk); slRd = 1'b1;
    #1 chk("R6 drive drops with rd", dataDrive, 0);
    @(negedge clk); slOe = 1'b1;
    #1 chk("R4 popped on release", flagEmpty, 1);

    // R4: long read strobe pops once
    @(negedge clk); fifoAddr = 2'd1; dataIn = 16'h0011; slWr = 1'b0;
    @(negedge clk); slWr = 1'b1;
    @(negedge clk); dataIn = 16'h0022; slWr = 1'b0;
    @(negedge clk); slWr = 1'b1;
    @(negedge clk); slOe = 1'b0; slRd = 1'b0;
    repeat (4) @(negedge clk);
    slRd = 1'b1; slOe = 1'b1;
    @(negedge clk);
    commit(2'd1, b, vl);
    chk("R4 single pop for long strobe", b, 8'd1);
    readWord(2'd1, v);
    chk("R4 remaining word", v, 16'h0022);

    // R7: inverted polarity, synchronous mode
    @(negedge clk); asyncMode = 1'b0;
    @(negedge clk);
    invPol = 3'b111; slRd = 1'b0; slWr = 1'b0; slOe = 1'b0;
    @(negedge clk);
    #1 chk("R7 low pins idle, no drive", dataDrive, 0);
    writeWord(2'd0, 16'h7777);
    commit(2'd0, b, vl);
    chk("R7 high-active write stored once", b, 8'd2);
    @(negedge clk); slOe = 1'b1;
    #1 chk("R7 high-active oe drives", dataDrive, 1);
    chk("R7 data", dataOut, 16'h7777);
    @(negedge clk); slOe = 1'b0;
    @(negedge clk);
    invPol = 3'b000; slRd = 1'b1; slWr = 1'b1; slOe = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks, nFails);
    $finish;
  end
endmodule